// File: doc/BRIEF.md
# Level-2 Cache Saturating Event Monitor

This block counts cache events for performance analysis. The cache drives a vector of fifteen single-cycle event strobes. Two identical 32-bit counters each pick one strobe through a 4-bit source code held in that counter's configuration register. A global run bit in a control register gates both counters. A source code of zero parks a counter on its own, whatever the run bit says.

Software reaches the block through a plain 32-bit register port. Writes land on the rising clock edge and reads are combinational from the address. Software normally zeroes a counter, lets it run for a polling interval, and reads it back. The counters stop at all-ones rather than wrapping, so an overrun is visible as the maximum value. The per-counter registers sit in descending order: the register for counter 1 is four bytes below the matching one for counter 0.

Top module: `l2_evmon`

## Requirements
- R1: After reset the run bit, both configuration registers and both counter values read back as zero.
- R2: Register offsets: run control at 0x200, counter 1 configuration at 0x204, counter 0 configuration at 0x208, counter 1 value at 0x20C, counter 0 value at 0x210. Any other offset reads zero, and a write to it changes no register.
- R3: A counter at 0xFFFFFFFF stays at 0xFFFFFFFF when further selected events arrive. It never wraps.
- R4: The run bit is bit 0 of the control register. While it is 0, neither counter advances.
- R5: A source code of 0 stops that counter, even with the run bit set and all strobes high.
- R6: A source code k from 1 to 15 in configuration bits [5:2] selects strobe evt_pulse[k-1]. The counter adds exactly one in each cycle in which that strobe is high, the run bit is 1 and the value is below all-ones.
- R7: Configuration bits [1:0] form the interrupt field (0 = interrupt off). The field is stored and read back, and it has no effect on counting.
- R8: A write to a value register loads the written data at the next clock edge. When a selected event occurs in the same cycle, the write wins and that event is dropped.
- R9: A write to one register leaves every other register unchanged. The control register keeps only bit 0, and its other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_pulse | input | 15 | Cache event strobes; bit k-1 is event source k |

## Verification
The hardest state to reach from the ports is the saturation boundary. Counting up from zero to 0xFFFFFFFF is out of reach. The bench instead preloads a value register to just below all-ones and then holds the selected strobe high for several more cycles than needed. The write-versus-event collision also needs exact timing. The bench raises the selected strobe and a value write in the same cycle, then checks that the loaded value is exact and that counting resumes one cycle later.

// File: rtl/l2_evmon_pkg.sv
package l2_evmon_pkg;
  localparam int DATA_W = 32;
  localparam int SRC_W  = 4;
  localparam int IRQ_W  = 2;
  localparam int N_EVT  = 15;
  localparam int N_CNT  = 2;
  localparam int ADDR_W = 12;
  localparam int STRIDE = 4;

  localparam logic [ADDR_W-1:0] CTRL_OFS = 12'h200;
  localparam logic [ADDR_W-1:0] CFG0_OFS = 12'h208;
  localparam logic [ADDR_W-1:0] VAL0_OFS = 12'h210;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [IRQ_W-1:0] irq;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Saturating increment: all-ones is sticky.
  function automatic logic [DATA_W-1:0] sat_inc(input logic [DATA_W-1:0] v,
                                                input logic step);
    if (step && (v != {DATA_W{1'b1}})) return v + 1'b1;
    return v;
  endfunction

  // Per-counter registers descend: higher index sits at lower offset.
  function automatic logic [ADDR_W-1:0] cfg_ofs(input int idx);
    return CFG0_OFS - ADDR_W'(STRIDE * idx);
  endfunction

  function automatic logic [ADDR_W-1:0] val_ofs(input int idx);
    return VAL0_OFS - ADDR_W'(STRIDE * idx);
  endfunction
endpackage

// File: rtl/l2_evmon_srcsel.sv
module l2_evmon_srcsel
  import l2_evmon_pkg::*;
#(
  parameter int NE = N_EVT,
  parameter int SW = SRC_W
) (
  input  logic [SW-1:0] src,
  input  logic [NE-1:0] evt,
  output logic          hit
);
  // Code 0 selects nothing; code k selects evt[k-1].
  always_comb begin
    hit = 1'b0;
    for (int k = 1; k <= NE; k++) begin
      if (src == SW'(k)) hit = evt[k-1];
    end
  end
endmodule

// File: rtl/l2_evmon_cfgreg.sv
module l2_evmon_cfgreg
  import l2_evmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= '0;
    else if (wr) cfg <= wdata[CFG_W-1:0];
  end

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg));
endmodule

// File: rtl/l2_evmon_counter.sv
module l2_evmon_counter
  import l2_evmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              step,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] nxt;
  logic              at_max;

  assign at_max = (value == {DATA_W{1'b1}});

  always_comb begin
    if (load) nxt = load_val;
    else      nxt = sat_inc(value, step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= nxt;
  end

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && at_max) |=> at_max);
  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (value == $past(load_val)));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(value));
  p_one_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((value == $past(value)) || (value == $past(value) + 1'b1)));
endmodule

// File: rtl/l2_evmon.sv
module l2_evmon
  import l2_evmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_EVT-1:0]  evt_pulse
);
  logic              run_q;
  logic              ctrl_wr;
  cfg_t              cfg_q   [N_CNT];
  logic [DATA_W-1:0] cnt_val [N_CNT];
  logic [N_CNT-1:0]  cfg_wr;
  logic [N_CNT-1:0]  val_wr;
  logic [N_CNT-1:0]  src_hit;
  logic [N_CNT-1:0]  cnt_step;

  assign ctrl_wr = reg_wr && (reg_addr == CTRL_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= 1'b0;
    else if (ctrl_wr) run_q <= reg_wdata[0];
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    assign cfg_wr[i] = reg_wr && (reg_addr == cfg_ofs(i));
    assign val_wr[i] = reg_wr && (reg_addr == val_ofs(i));

    l2_evmon_cfgreg i_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr[i]),
      .wdata (reg_wdata),
      .cfg   (cfg_q[i])
    );

    l2_evmon_srcsel #(.NE(N_EVT), .SW(SRC_W)) i_sel (
      .src (cfg_q[i].src),
      .evt (evt_pulse),
      .hit (src_hit[i])
    );

    assign cnt_step[i] = run_q && src_hit[i];

    l2_evmon_counter i_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (val_wr[i]),
      .load_val (reg_wdata),
      .step     (cnt_step[i]),
      .value    (cnt_val[i])
    );

    p_no_run_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !val_wr[i]) |=> $stable(cnt_val[i]));
    p_src_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[i].src == '0 && !val_wr[i]) |=> $stable(cnt_val[i]));
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_OFS) reg_rdata[0] = run_q;
    for (int i = 0; i < N_CNT; i++) begin
      if (reg_addr == cfg_ofs(i)) reg_rdata[CFG_W-1:0] = cfg_q[i];
      if (reg_addr == val_ofs(i)) reg_rdata = cnt_val[i];
    end
  end

  p_run_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(run_q));
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_wr, cfg_wr, val_wr}));
endmodule

// File: tb/test_l2_evmon.sv
module test_l2_evmon;
  localparam int PERIOD = 10;
  localparam int NV = 8;
  localparam logic [3:0]  V_SRC [NV] = '{4'd1, 4'd1, 4'd15, 4'd9, 4'd9, 4'd0, 4'd5, 4'd14};
  localparam logic [14:0] V_EVT [NV] = '{15'h0001, 15'h0002, 15'h4000, 15'h0100,
                                          15'h7EFF, 15'h7FFF, 15'h7FFF, 15'h2000};
  localparam logic [31:0] V_EXP [NV] = '{32'd1, 32'd0, 32'd1, 32'd1, 32'd0, 32'd0, 32'd1, 32'd1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [14:0] evt_pulse = '0;
  int n_chk = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  l2_evmon i_l2_evmon (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse)
  );

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    n_chk++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic pulse(input logic [14:0] e, input int n);
    evt_pulse = e;
    repeat (n) @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", 12'h200, 32'h0);
    chk("R1", 12'h204, 32'h0);
    chk("R1", 12'h208, 32'h0);
    chk("R1", 12'h20C, 32'h0);
    chk("R1", 12'h210, 32'h0);
    // R2 unmapped offset
    wreg(12'h214, 32'hFFFFFFFF);
    chk("R2", 12'h214, 32'h0);
    chk("R2", 12'h208, 32'h0);
    // R7 R9 config write to counter 0 only
    wreg(12'h208, 32'h0000000E);
    chk("R7", 12'h208, 32'h0000000E);
    chk("R9", 12'h204, 32'h0);
    // R6 R5 vector table
    wreg(12'h200, 32'h1);
    chk("R4", 12'h200, 32'h1);
    for (int v = 0; v < NV; v++) begin
      wreg(12'h208, {26'd0, V_SRC[v], 2'b00});
      wreg(12'h210, 32'h0);
      pulse(V_EVT[v], 1);
      chk("R6", 12'h210, V_EXP[v]);
      chk("R5", 12'h20C, 32'h0);
    end
    // R6 multi-cycle count
    wreg(12'h208, {26'd0, 4'd3, 2'b00});
    wreg(12'h210, 32'h0);
    pulse(15'h0004, 6);
    chk("R6", 12'h210, 32'd6);
    // R4 run bit off
    wreg(12'h200, 32'hFFFFFFFE);
    chk("R9", 12'h200, 32'h0);
    chk("R9", 12'h208, 32'h0000000C);
    pulse(15'h7FFF, 3);
    chk("R4", 12'h210, 32'd6);
    wreg(12'h200, 32'h1);
    // R2 counter 1 at the lower offsets
    wreg(12'h204, {26'd0, 4'd7, 2'b00});
    wreg(12'h20C, 32'h0);
    wreg(12'h210, 32'h0);
    wreg(12'h208, 32'h0);
    pulse(15'h0040, 4);
    chk("R2", 12'h20C, 32'd4);
    chk("R2", 12'h210, 32'd0);
    // R3 saturation
    wreg(12'h208, {26'd0, 4'd1, 2'b00});
    wreg(12'h210, 32'hFFFFFFFD);
    pulse(15'h0001, 5);
    chk("R3", 12'h210, 32'hFFFFFFFF);
    pulse(15'h0001, 3);
    chk("R3", 12'h210, 32'hFFFFFFFF);
    // R8 write wins over a coincident event
    evt_pulse = 15'h0001;
    wreg(12'h210, 32'h10);
    chk("R8", 12'h210, 32'h10);
    @(negedge clk);
    evt_pulse = '0;
    chk("R8", 12'h210, 32'h11);
    // R7 interrupt field does not affect counting
    wreg(12'h208, {26'd0, 4'd2, 2'b11});
    wreg(12'h210, 32'h0);
    pulse(15'h0002, 2);
    chk("R7", 12'h210, 32'd2);
    chk("R7", 12'h208, 32'h0000000B);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule